// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog for a small controller. After a hardware reset it is off and does nothing. Software turns it on by writing two key bytes, 0x1E and then 0xE1, to a write-only service address. From then on a counter advances once per machine-cycle tick. Writing the same pair again restarts the count from zero. No write can turn the watchdog off again. Only a hardware reset or the watchdog's own overflow does that. If the count runs out, the block raises a one-cycle internal reset request. Unless suppressed, it also drives a reset-out line high for a fixed number of oscillator clocks.

Two control inputs come from an auxiliary register held elsewhere in the chip. One suppresses the reset-out drive, so the pad stays input-only. The other selects whether counting freezes while the core is idle. During power-down the count is frozen. After a wake-up by interrupt it stays frozen until the wake-up line is seen high again.

Three state machines do the work:

- **Key detector**, states `KEY_IDLE` and `KEY_HALF`:
  - `KEY_IDLE` to `KEY_HALF` on 0x1E.
  - `KEY_HALF` to `KEY_IDLE` on any service write, which completes the key only if the byte is 0xE1.
  - Either state to `KEY_IDLE` on overflow.
- **Cycle counter**, states `WD_OFF` and `WD_RUN`:
  - `WD_OFF` to `WD_RUN` on a completed key.
  - `WD_RUN` to `WD_OFF` on overflow.
  - `WD_RUN` stays in `WD_RUN` and clears the count on a completed key.
- **Pulse generator**, states `PO_QUIET` and `PO_DRIVE`:
  - `PO_QUIET` to `PO_DRIVE` on an unsuppressed overflow.
  - `PO_DRIVE` to `PO_QUIET` when the pulse length has elapsed.

Top module: `keyed_watchdog`

## Requirements
- R1: After hardware reset (`rst_n` low) the watchdog is disarmed and both outputs are low. Unarmed, it never requests a reset however many ticks arrive. Asserting `rst_n` ends a reset-out pulse at once.
- R2: The watchdog arms on two service writes in a row: 0x1E, then 0xE1. A service write is `wr_en` high with `wr_addr` equal to `SVC_ADDR` (default 0xA6). After arming, the request rises on the clock after the 2^`CNT_W`−1st counted tick (16383 at default width).
- R3: In the key detector, any service write other than 0xE1 that follows 0x1E returns it to the start. Writes to other addresses leave its state unchanged. After each complete pair it starts over.
- R4: While armed, a complete key pair restarts the count from zero. Partial or wrong sequences neither restart the count nor disarm the watchdog.
- R5: An overflow raises `wdt_reset_req` for exactly one clock and disarms the watchdog. No further request occurs until it is armed again.
- R6: With `rto_dis` low at overflow, `rst_out_drive` goes high in the same clock as the request. It stays high for exactly `PULSE_LEN` (default 98) clocks.
- R7: With `rto_dis` high at overflow, `rst_out_drive` stays low while the request is still raised.
- R8: The count advances only on clocks where `mc_tick` is high.
- R9: With `idle_halt` high, ticks during `idle` are not counted and counting resumes when `idle` falls. With `idle_halt` low, ticks during `idle` are counted.
- R10: Ticks are not counted while `pdown` is high. After `pdown` falls, ticks stay uncounted until `wake_line` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| mc_tick | input | 1 | Machine-cycle tick, one clock wide |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| idle | input | 1 | Core is in idle mode |
| pdown | input | 1 | Core is in power-down mode |
| wake_line | input | 1 | Wake-up interrupt line, low while held |
| rto_dis | input | 1 | Suppress reset-out drive |
| idle_halt | input | 1 | Freeze counting while idle |
| wdt_reset_req | output | 1 | Internal reset request, one clock on overflow |
| rst_out_drive | output | 1 | Drive enable for the reset pad |

## Verification
The assertions assume that `mc_tick`, `idle`, `pdown` and the two control bits are synchronous to `clk` and settle between edges. They also assume a request can only follow a clock on which a tick was accepted. The bench drives every input on the falling edge, so each value is stable for a whole cycle before the rising edge samples it. It changes the mode inputs only while no reset-out pulse is under way, except in the deliberate mid-pulse reset test. The bench overrides `CNT_W` to 7 so that overflow comes after 127 ticks and every ordering fits a short run.

// File: rtl/kwd_pkg.sv
`timescale 1ns/1ps
package kwd_pkg;
    typedef enum logic { KEY_IDLE, KEY_HALF } key_state_t;
    typedef enum logic { WD_OFF, WD_RUN } wd_state_t;
    typedef enum logic { PO_QUIET, PO_DRIVE } po_state_t;

    localparam logic [7:0] KEY_BYTE_A = 8'h1E;
    localparam logic [7:0] KEY_BYTE_B = 8'hE1;
endpackage

// File: rtl/kwd_key_fsm.sv
`timescale 1ns/1ps
module kwd_key_fsm
    import kwd_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] SVC_ADDR = 'hA6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              key_ok
);
    localparam logic [DATA_W-1:0] BYTE_A = DATA_W'(KEY_BYTE_A);
    localparam logic [DATA_W-1:0] BYTE_B = DATA_W'(KEY_BYTE_B);

    key_state_t state_q, state_d;
    logic       svc_hit;

    assign svc_hit = wr_en && (wr_addr == SVC_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KEY_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        key_ok  = 1'b0;
        unique case (state_q)
            KEY_IDLE: begin
                if (svc_hit && wr_data == BYTE_A) state_d = KEY_HALF;
            end
            KEY_HALF: begin
                if (svc_hit) begin
                    state_d = KEY_IDLE;
                    key_ok  = (wr_data == BYTE_B);
                end
            end
        endcase
        if (clr) state_d = KEY_IDLE;
    end
endmodule

// File: rtl/kwd_tick_gate.sv
`timescale 1ns/1ps
module kwd_tick_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic mc_tick,
    input  logic idle,
    input  logic idle_halt,
    input  logic pdown,
    input  logic wake_line,
    output logic tick_en
);
    // Set while in power-down; released once the wake-up line is seen high.
    logic pd_hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         pd_hold_q <= 1'b0;
        else if (pdown)     pd_hold_q <= 1'b1;
        else if (wake_line) pd_hold_q <= 1'b0;
    end

    always_comb begin
        tick_en = mc_tick
                  && !pdown
                  && !(pd_hold_q && !wake_line)
                  && !(idle && idle_halt);
    end
endmodule

// File: rtl/kwd_cycle_count.sv
`timescale 1ns/1ps
module kwd_cycle_count
    import kwd_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic key_ok,
    input  logic tick_en,
    output logic armed,
    output logic ovf
);
    // The count overflows on the tick that would take it to all ones.
    localparam logic [CNT_W-1:0] LAST = {{(CNT_W-1){1'b1}}, 1'b0};

    wd_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        ovf     = 1'b0;
        unique case (state_q)
            WD_OFF: begin
                if (key_ok) begin
                    state_d = WD_RUN;
                    cnt_d   = '0;
                end
            end
            WD_RUN: begin
                if (key_ok) begin
                    cnt_d = '0;
                end else if (tick_en && cnt_q == LAST) begin
                    ovf     = 1'b1;
                    state_d = WD_OFF;
                    cnt_d   = '0;
                end else if (tick_en) begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
        endcase
    end

    assign armed = (state_q == WD_RUN);
endmodule

// File: rtl/kwd_pulse_out.sv
`timescale 1ns/1ps
module kwd_pulse_out
    import kwd_pkg::*;
#(
    parameter int PULSE_LEN = 98
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic suppress,
    output logic drive
);
    localparam int PW = $clog2(PULSE_LEN + 1);
    localparam logic [PW-1:0] P_END = PW'(PULSE_LEN - 1);

    po_state_t     state_q, state_d;
    logic [PW-1:0] pcnt_q, pcnt_d;
    logic          start;

    assign start = fire && !suppress;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PO_QUIET;
            pcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            pcnt_q  <= pcnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        pcnt_d  = pcnt_q;
        unique case (state_q)
            PO_QUIET: begin
                if (start) begin
                    state_d = PO_DRIVE;
                    pcnt_d  = '0;
                end
            end
            PO_DRIVE: begin
                if (start)               pcnt_d  = '0;
                else if (pcnt_q == P_END) state_d = PO_QUIET;
                else                     pcnt_d  = pcnt_q + 1'b1;
            end
        endcase
    end

    always_comb begin
        drive = (state_q == PO_DRIVE);
    end
endmodule

// File: rtl/keyed_watchdog.sv
`timescale 1ns/1ps
module keyed_watchdog #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] SVC_ADDR = 'hA6,
    parameter int CNT_W = 14,
    parameter int PULSE_LEN = 98
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mc_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              idle,
    input  logic              pdown,
    input  logic              wake_line,
    input  logic              rto_dis,
    input  logic              idle_halt,
    output logic              wdt_reset_req,
    output logic              rst_out_drive
);
    logic key_ok;
    logic tick_en;
    logic wd_armed;
    logic ovf_evt;

    kwd_key_fsm #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .SVC_ADDR(SVC_ADDR)
    ) u_key (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (ovf_evt),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .key_ok (key_ok)
    );

    kwd_tick_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .mc_tick  (mc_tick),
        .idle     (idle),
        .idle_halt(idle_halt),
        .pdown    (pdown),
        .wake_line(wake_line),
        .tick_en  (tick_en)
    );

    kwd_cycle_count #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .key_ok (key_ok),
        .tick_en(tick_en),
        .armed  (wd_armed),
        .ovf    (ovf_evt)
    );

    kwd_pulse_out #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (ovf_evt),
        .suppress(rto_dis),
        .drive   (rst_out_drive)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wdt_reset_req <= 1'b0;
        else        wdt_reset_req <= ovf_evt;
    end
endmodule

// File: rtl/kwd_checker.sv
`timescale 1ns/1ps
module kwd_checker #(
    parameter int PULSE_LEN = 98
) (
    input logic clk,
    input logic rst_n,
    input logic mc_tick,
    input logic idle,
    input logic idle_halt,
    input logic pdown,
    input logic rto_dis,
    input logic armed,
    input logic ovf,
    input logic req,
    input logic drive
);
    logic [15:0] high_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     high_len <= '0;
        else if (drive) high_len <= high_len + 1'b1;
        else            high_len <= '0;
    end

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !req); // R5
    AST_OVF_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> !armed); // R5
    AST_ARM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !ovf) |=> armed); // R4
    AST_DRIVE_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive) |-> req); // R6
    AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drive) |-> (high_len == 16'(PULSE_LEN))); // R6
    AST_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive) |-> $past(!rto_dis)); // R7
    AST_REQ_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> $past(mc_tick)); // R8
    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> !$past(idle && idle_halt)); // R9
    AST_PDOWN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> !$past(pdown)); // R10
endmodule

bind keyed_watchdog kwd_checker #(.PULSE_LEN(PULSE_LEN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mc_tick  (mc_tick),
    .idle     (idle),
    .idle_halt(idle_halt),
    .pdown    (pdown),
    .rto_dis  (rto_dis),
    .armed    (wd_armed),
    .ovf      (ovf_evt),
    .req      (wdt_reset_req),
    .drive    (rst_out_drive)
);

// File: tb/tb_keyed_watchdog.sv
`timescale 1ns/1ps
module tb_keyed_watchdog;
    localparam int CNT_W = 7;
    localparam int LIMIT = (1 << CNT_W) - 1;
    localparam int PLEN  = 98;
    localparam logic [7:0] SVC = 8'hA6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mc_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       idle = 1'b0;
    logic       pdown = 1'b0;
    logic       wake_line = 1'b1;
    logic       rto_dis = 1'b0;
    logic       idle_halt = 1'b0;
    logic       wdt_reset_req;
    logic       rst_out_drive;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    keyed_watchdog #(.CNT_W(CNT_W), .PULSE_LEN(PLEN)) dut (
        .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .idle(idle), .pdown(pdown),
        .wake_line(wake_line), .rto_dis(rto_dis), .idle_halt(idle_halt),
        .wdt_reset_req(wdt_reset_req), .rst_out_drive(rst_out_drive)
    );

    // Per entry: {addr1, data1, addr2, data2, addr3, data3, expect_armed}
    localparam int NV = 7;
    localparam logic [48:0] VEC [NV] = '{
        {8'hA6, 8'h1E, 8'hA6, 8'hE1, 8'h00, 8'h00, 1'b1},
        {8'hA6, 8'hE1, 8'hA6, 8'h1E, 8'h00, 8'h00, 1'b0},
        {8'hA6, 8'h1E, 8'hA6, 8'h1E, 8'hA6, 8'hE1, 1'b0},
        {8'hA6, 8'h1E, 8'hA5, 8'h55, 8'hA6, 8'hE1, 1'b1},
        {8'hA5, 8'h1E, 8'hA6, 8'hE1, 8'h00, 8'h00, 1'b0},
        {8'hA6, 8'h1E, 8'hA6, 8'h00, 8'hA6, 8'hE1, 1'b0},
        {8'hA6, 8'h55, 8'hA6, 8'h1E, 8'hA6, 8'hE1, 1'b1}
    };

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; mc_tick = 1'b0; wr_en = 1'b0; idle = 1'b0; pdown = 1'b0;
        wake_line = 1'b1; rto_dis = 1'b0; idle_halt = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic arm();
        wr(SVC, 8'h1E);
        wr(SVC, 8'hE1);
    endtask

    // Runs n clocks with mc_tick high, reporting the first request clock,
    // the number of request clocks and the number of drive-high clocks.
    task automatic run(input int n, output int first, output int nreq, output int ndrv);
        first = -1; nreq = 0; ndrv = 0;
        mc_tick = 1'b1;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (wdt_reset_req) begin
                nreq++;
                if (first < 0) first = i;
            end
            if (rst_out_drive) ndrv++;
        end
        mc_tick = 1'b0;
    endtask

    initial begin
        #900us;
        if (!done) begin
            nerr++;
            $display("FAIL watchdog timeout actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        int f, nr, nd;

        // R1: reset state, and no request while unarmed
        do_reset();
        check(wdt_reset_req == 1'b0, "R1 req after reset", wdt_reset_req, 0);
        check(rst_out_drive == 1'b0, "R1 drive after reset", rst_out_drive, 0);
        run(2 * LIMIT, f, nr, nd);
        check(nr == 0, "R1 unarmed requests", nr, 0);

        // R2 / R3: key sequences from the table
        for (int v = 0; v < NV; v++) begin
            do_reset();
            wr(VEC[v][48:41], VEC[v][40:33]);
            wr(VEC[v][32:25], VEC[v][24:17]);
            wr(VEC[v][16:9],  VEC[v][8:1]);
            run(2 * LIMIT, f, nr, nd);
            if (VEC[v][0]) check(f == LIMIT, $sformatf("R2 R3 vector %0d first req", v), f, LIMIT);
            else           check(f == -1,    $sformatf("R3 vector %0d first req", v), f, -1);
        end

        // R5 / R6: single request, disarm, 98-clock drive
        do_reset();
        arm();
        run(2 * LIMIT + 10, f, nr, nd);
        check(f == LIMIT, "R2 overflow clock", f, LIMIT);
        check(nr == 1, "R5 single request", nr, 1);
        check(nd == PLEN, "R6 drive length", nd, PLEN);

        // R1: hardware reset cuts a pulse short
        do_reset();
        arm();
        run(LIMIT + 10, f, nr, nd);
        check(rst_out_drive == 1'b1, "R6 drive active mid-pulse", rst_out_drive, 1);
        rst_n = 1'b0;
        #1;
        check(rst_out_drive == 1'b0, "R1 reset ends pulse", rst_out_drive, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R7: suppressed reset-out
        do_reset();
        rto_dis = 1'b1;
        arm();
        run(LIMIT + 110, f, nr, nd);
        check(f == LIMIT, "R7 request still raised", f, LIMIT);
        check(nd == 0, "R7 no drive", nd, 0);

        // R4: a full pair restarts the count
        do_reset();
        arm();
        run(100, f, nr, nd);
        arm();
        run(LIMIT, f, nr, nd);
        check(f == LIMIT, "R4 service restarts", f, LIMIT);

        // R4: partial sequences neither restart nor disarm
        do_reset();
        arm();
        run(100, f, nr, nd);
        wr(SVC, 8'h1E); wr(SVC, 8'h55); wr(SVC, 8'hE1); wr(SVC, 8'h00);
        run(LIMIT, f, nr, nd);
        check(f == LIMIT - 100, "R4 partial keeps count", f, LIMIT - 100);

        // R8: clocks without mc_tick are not counted
        do_reset();
        arm();
        run(60, f, nr, nd);
        nr = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (wdt_reset_req) nr++;
        end
        check(nr == 0, "R8 no request without ticks", nr, 0);
        run(LIMIT, f, nr, nd);
        check(f == LIMIT - 60, "R8 resumes count", f, LIMIT - 60);

        // R9: idle with halt bit set freezes the count
        do_reset();
        idle_halt = 1'b1; idle = 1'b1;
        arm();
        run(50, f, nr, nd);
        check(nr == 0, "R9 halted idle", nr, 0);
        idle = 1'b0;
        run(LIMIT, f, nr, nd);
        check(f == LIMIT, "R9 resume after idle", f, LIMIT);

        // R9: idle with halt bit clear keeps counting
        do_reset();
        idle_halt = 1'b0; idle = 1'b1;
        arm();
        run(LIMIT, f, nr, nd);
        check(f == LIMIT, "R9 counting in idle", f, LIMIT);

        // R10: power-down and held wake line
        do_reset();
        arm();
        run(20, f, nr, nd);
        pdown = 1'b1;
        run(50, f, nr, nd);
        check(nr == 0, "R10 frozen in power-down", nr, 0);
        pdown = 1'b0; wake_line = 1'b0;
        run(40, f, nr, nd);
        check(nr == 0, "R10 frozen while wake line low", nr, 0);
        wake_line = 1'b1;
        run(LIMIT, f, nr, nd);
        check(f == LIMIT - 20, "R10 resumes after wake", f, LIMIT - 20);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule